// File: doc/BRIEF.md
# Secure-Exit Rendezvous Controller

This block sequences the shutdown of a protected execution session on a platform with one initiating processor and a parameterised number of responding processors. When the initiator asks to leave the session, the controller broadcasts an exit event. Every participating responder takes the event, saves its prior execution state and acknowledges. The controller gathers these acknowledges in a status vector, and only when every active responder has answered does it release them. The release is a continue message followed on the next cycle by a close message for the chipset private space. After that the secure-session flag drops and the initiator's external pin events are unmasked.

Each responder unmasks its own SMI, INIT, A20M and NMI pin events on the continue message. It then either re-enters halt, goes to wait-for-startup after dropping its boot-processor status, or resumes the interrupted instruction, depending on the state it saved. A processor that is still in virtualization operation when the exit event reaches it goes to an illegal-event shutdown and does not acknowledge.

Top module: `sexit_rdv_ctrl`

## Requirements
- R1: After reset the session flag is 0, every pin-mask bit is 0, the acknowledge vector is 0 and no message output is high.
- R2: A session-open pulse while idle with the flag clear sets the session flag and all four pin-mask bits (bit order SMI, INIT, A20M, NMI, all set = 4'hF) of the initiator and of every responder. An exit request while the flag is clear produces no broadcast.
- R3: An exit request in the idle state with the flag set raises exit_bcast for exactly one cycle, starting in the cycle after the request. The acknowledge vector reads 0 in the cycle after the broadcast.
- R4: Every active responder that is not in virtualization operation pulses its acknowledge output for one cycle, in the cycle after the broadcast. Its bit in ack_vec reads 1 from the following cycle.
- R5: An active responder in virtualization operation at the broadcast raises resp_shutdown instead of acknowledging and holds it until reset. The continue message is then never sent.
- R6: If the initiator is in virtualization operation when it sees its own broadcast, init_shutdown goes high and no continue message is sent.
- R7: The continue message is a one-cycle pulse, issued only once the acknowledge bits of all active responders are set (inactive bits do not count). With no active responder it comes two cycles after the broadcast, otherwise three. The close message is a one-cycle pulse in the next cycle.
- R8: In the cycle after the close message the session flag is 0, the initiator's pin mask is 0 and init_done pulses for one cycle.
- R9: In the cycle after the continue message every acknowledged responder's pin mask is 0. Inactive responders keep their mask.
- R10: On the continue message a responder whose saved prior state is 2'b01 raises resp_halt. For 2'b10 it pulses resp_bsp_clr and raises resp_wait_sipi. For 2'b00 or 2'b11 it pulses resp_resume.
- R11: The prior state is captured when the exit event is taken. Changing resp_prior afterwards has no effect on the resume action.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sess_open | input | 1 | Pulse: a protected session has been entered |
| exit_req | input | 1 | Pulse: initiator requests session exit |
| init_virt | input | 1 | Initiator is in virtualization operation |
| resp_active | input | N_RESP | Responder participates in the rendezvous |
| resp_virt | input | N_RESP | Responder is in virtualization operation |
| resp_prior | input | 2*N_RESP | Per-responder prior execution state code |
| exit_bcast | output | 1 | Exit event broadcast pulse |
| cont_msg | output | 1 | Continue message pulse |
| close_msg | output | 1 | Close-private-space message pulse |
| sess_flag | output | 1 | Secure session active |
| all_acked | output | 1 | All active responders acknowledged |
| ack_vec | output | N_RESP | Collected acknowledge bits |
| init_pin_mask | output | 4 | Initiator pin-event masks |
| init_shutdown | output | 1 | Initiator illegal-event shutdown |
| init_done | output | 1 | Initiator proceeds to next instruction |
| resp_ack | output | N_RESP | Exit event taken and acknowledged (pulse) |
| resp_pin_mask | output | 4*N_RESP | Responder pin-event masks |
| resp_halt | output | N_RESP | Responder back in halt |
| resp_wait_sipi | output | N_RESP | Responder waiting for startup message |
| resp_bsp_clr | output | N_RESP | Boot-processor bit clear and reinit pulse |
| resp_resume | output | N_RESP | Resume pending instruction pulse |
| resp_shutdown | output | N_RESP | Responder illegal-event shutdown |

## Verification
A corrupted acknowledge vector shows at the ports within a cycle. A stale bit lets cont_msg come one cycle early. A lost bit leaves cont_msg silent forever. A wrong initiator state shows up as a broadcast without a session, or as a continue and close out of order or on the same cycle. A wrongly saved prior state shows in the cycle after continue, as the wrong one of halt, wait-for-startup or resume. The bench therefore checks every output at each cycle offset from the request.

// File: rtl/sexit_pkg.sv
// Shared types for the secure-exit rendezvous controller.
package sexit_pkg;
    localparam int PIN_W = 4;   // SMI, INIT, A20M, NMI

    typedef enum logic [2:0] {
        I_IDLE, I_WAIT_EVT, I_POLL, I_CLOSE, I_FIN, I_SHUT
    } init_st_t;

    typedef enum logic [2:0] {
        R_IDLE, R_WAIT_CONT, R_HALT, R_WFS, R_SHUT
    } resp_st_t;

    typedef enum logic [1:0] {
        PRIOR_RUN   = 2'b00,
        PRIOR_HALT  = 2'b01,
        PRIOR_SLEEP = 2'b10,
        PRIOR_OTHER = 2'b11
    } prior_t;
endpackage

// File: rtl/sexit_ack_collect.sv
// Acknowledge collector: one sticky bit per responder, cleared by the
// exit broadcast. Done is the AND over active responders.
// Assumes the active set is stable during a rendezvous.
module sexit_ack_collect #(
    parameter int N_RESP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [N_RESP-1:0] ack_in,
    input  logic [N_RESP-1:0] active,
    output logic [N_RESP-1:0] ack_vec,
    output logic              all_done
);
    logic [N_RESP-1:0] vec_q;

    // Accumulate acknowledges; clear on each new broadcast.
    always_ff @(posedge clk) begin
        if (!rst_n)    vec_q <= '0;
        else if (clr)  vec_q <= '0;
        else           vec_q <= vec_q | ack_in;
    end

    assign ack_vec  = vec_q;
    assign all_done = &(vec_q | ~active);

    p_clear_on_bcast_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ack_vec == '0));

    p_no_spurious_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((ack_vec & ~$past(ack_vec) & ~$past(ack_in)) == '0));
endmodule

// File: rtl/sexit_init_seq.sv
// Initiator sequencer: opens the session, broadcasts exit, waits for
// its own exit event, polls for all acknowledges, then issues continue
// and close on consecutive cycles, clears the session flag and unmasks
// its pin events. Assumes exit_req and sess_open are single-cycle.
module sexit_init_seq
    import sexit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sess_open,
    input  logic             exit_req,
    input  logic             init_virt,
    input  logic             all_done,
    output logic             exit_bcast,
    output logic             cont_msg,
    output logic             close_msg,
    output logic             sess_flag,
    output logic [PIN_W-1:0] init_pin_mask,
    output logic             init_shutdown,
    output logic             init_done,
    output logic             sess_start
);
    init_st_t         st_q;
    logic             flag_q, bcast_q, cont_q, close_q, done_q;
    logic [PIN_W-1:0] mask_q;

    // Session start is accepted only when idle with no session active.
    assign sess_start = sess_open && (st_q == I_IDLE) && !flag_q;

    // Main sequencing FSM with single-cycle message pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= I_IDLE;
            flag_q  <= 1'b0;
            mask_q  <= '0;
            bcast_q <= 1'b0;
            cont_q  <= 1'b0;
            close_q <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            bcast_q <= 1'b0;
            cont_q  <= 1'b0;
            close_q <= 1'b0;
            done_q  <= 1'b0;
            case (st_q)
                I_IDLE: begin
                    if (sess_start) begin
                        flag_q <= 1'b1;
                        mask_q <= '1;
                    end else if (exit_req && flag_q) begin
                        bcast_q <= 1'b1;
                        st_q    <= I_WAIT_EVT;
                    end
                end
                I_WAIT_EVT: begin
                    if (bcast_q) st_q <= init_virt ? I_SHUT : I_POLL;
                end
                I_POLL: begin
                    if (all_done) begin
                        cont_q <= 1'b1;
                        st_q   <= I_CLOSE;
                    end
                end
                I_CLOSE: begin
                    close_q <= 1'b1;
                    st_q    <= I_FIN;
                end
                I_FIN: begin
                    flag_q <= 1'b0;
                    mask_q <= '0;
                    done_q <= 1'b1;
                    st_q   <= I_IDLE;
                end
                default: st_q <= I_SHUT;
            endcase
        end
    end

    assign exit_bcast    = bcast_q;
    assign cont_msg      = cont_q;
    assign close_msg     = close_q;
    assign sess_flag     = flag_q;
    assign init_pin_mask = mask_q;
    assign init_shutdown = (st_q == I_SHUT);
    assign init_done     = done_q;

    p_bcast_needs_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        exit_bcast |-> sess_flag);

    p_close_after_cont_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cont_msg |=> (close_msg && !cont_msg));

    p_cont_needs_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cont_msg |-> $past(all_done));

    p_msgs_exclusive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({exit_bcast, cont_msg, close_msg}));

    p_flag_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        close_msg |=> (!sess_flag && init_done && (init_pin_mask == '0)));

    p_shutdown_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        init_shutdown |=> (init_shutdown && !cont_msg));
endmodule

// File: rtl/sexit_resp_agent.sv
// Responder agent: takes the exit event, saves its prior state and
// acknowledges (or shuts down if in virtualization operation), then on
// continue unmasks its pin events and performs the saved resume action.
// Assumes exit_evt and cont_evt are single-cycle pulses.
module sexit_resp_agent
    import sexit_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sess_start,
    input  logic             exit_evt,
    input  logic             cont_evt,
    input  logic             active,
    input  logic             virt,
    input  logic [1:0]       prior,
    output logic             ack,
    output logic [PIN_W-1:0] pin_mask,
    output logic             halted,
    output logic             wait_sipi,
    output logic             bsp_clr,
    output logic             resume,
    output logic             shutdown
);
    resp_st_t         st_q;
    prior_t           prior_q;
    logic             ack_q, bsp_q, resume_q;
    logic [PIN_W-1:0] mask_q;

    // Per-responder exit handling and resume FSM.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= R_IDLE;
            prior_q  <= PRIOR_RUN;
            ack_q    <= 1'b0;
            bsp_q    <= 1'b0;
            resume_q <= 1'b0;
            mask_q   <= '0;
        end else begin
            ack_q    <= 1'b0;
            bsp_q    <= 1'b0;
            resume_q <= 1'b0;
            if (sess_start && st_q != R_SHUT) begin
                st_q   <= R_IDLE;
                mask_q <= '1;
            end else begin
                case (st_q)
                    R_IDLE: begin
                        if (exit_evt && active) begin
                            if (virt) begin
                                st_q <= R_SHUT;
                            end else begin
                                ack_q   <= 1'b1;
                                prior_q <= prior_t'(prior);
                                st_q    <= R_WAIT_CONT;
                            end
                        end
                    end
                    R_WAIT_CONT: begin
                        if (cont_evt) begin
                            mask_q <= '0;
                            case (prior_q)
                                PRIOR_HALT:  st_q <= R_HALT;
                                PRIOR_SLEEP: begin
                                    bsp_q <= 1'b1;
                                    st_q  <= R_WFS;
                                end
                                default: begin
                                    resume_q <= 1'b1;
                                    st_q     <= R_IDLE;
                                end
                            endcase
                        end
                    end
                    R_HALT, R_WFS, R_SHUT: st_q <= st_q;
                    default: st_q <= R_SHUT;
                endcase
            end
        end
    end

    assign ack       = ack_q;
    assign pin_mask  = mask_q;
    assign halted    = (st_q == R_HALT);
    assign wait_sipi = (st_q == R_WFS);
    assign bsp_clr   = bsp_q;
    assign resume    = resume_q;
    assign shutdown  = (st_q == R_SHUT);

    p_shutdown_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        shutdown |=> (shutdown && !ack));

    p_ack_only_on_event_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> $past(exit_evt && active && !virt));

    p_unmask_on_cont_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cont_evt && st_q == R_WAIT_CONT) |=> (pin_mask == '0));

    p_one_action_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bsp_clr, resume, halted && $rose(halted)}));
endmodule

// File: rtl/sexit_rdv_ctrl.sv
// Top of the secure-exit rendezvous controller: one initiator sequencer,
// an acknowledge collector and N_RESP responder agents.
// Assumes responder inputs are stable while a rendezvous is in flight.
module sexit_rdv_ctrl
    import sexit_pkg::*;
#(
    parameter int N_RESP = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      sess_open,
    input  logic                      exit_req,
    input  logic                      init_virt,
    input  logic [N_RESP-1:0]         resp_active,
    input  logic [N_RESP-1:0]         resp_virt,
    input  logic [2*N_RESP-1:0]       resp_prior,
    output logic                      exit_bcast,
    output logic                      cont_msg,
    output logic                      close_msg,
    output logic                      sess_flag,
    output logic                      all_acked,
    output logic [N_RESP-1:0]         ack_vec,
    output logic [PIN_W-1:0]          init_pin_mask,
    output logic                      init_shutdown,
    output logic                      init_done,
    output logic [N_RESP-1:0]         resp_ack,
    output logic [PIN_W*N_RESP-1:0]   resp_pin_mask,
    output logic [N_RESP-1:0]         resp_halt,
    output logic [N_RESP-1:0]         resp_wait_sipi,
    output logic [N_RESP-1:0]         resp_bsp_clr,
    output logic [N_RESP-1:0]         resp_resume,
    output logic [N_RESP-1:0]         resp_shutdown
);
    logic sess_start;

    sexit_init_seq u_init (
        .clk           (clk),
        .rst_n         (rst_n),
        .sess_open     (sess_open),
        .exit_req      (exit_req),
        .init_virt     (init_virt),
        .all_done      (all_acked),
        .exit_bcast    (exit_bcast),
        .cont_msg      (cont_msg),
        .close_msg     (close_msg),
        .sess_flag     (sess_flag),
        .init_pin_mask (init_pin_mask),
        .init_shutdown (init_shutdown),
        .init_done     (init_done),
        .sess_start    (sess_start)
    );

    sexit_ack_collect #(.N_RESP(N_RESP)) u_ack (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (exit_bcast),
        .ack_in   (resp_ack),
        .active   (resp_active),
        .ack_vec  (ack_vec),
        .all_done (all_acked)
    );

    for (genvar g = 0; g < N_RESP; g++) begin : g_resp
        sexit_resp_agent u_agent (
            .clk       (clk),
            .rst_n     (rst_n),
            .sess_start(sess_start),
            .exit_evt  (exit_bcast),
            .cont_evt  (cont_msg),
            .active    (resp_active[g]),
            .virt      (resp_virt[g]),
            .prior     (resp_prior[2*g +: 2]),
            .ack       (resp_ack[g]),
            .pin_mask  (resp_pin_mask[PIN_W*g +: PIN_W]),
            .halted    (resp_halt[g]),
            .wait_sipi (resp_wait_sipi[g]),
            .bsp_clr   (resp_bsp_clr[g]),
            .resume    (resp_resume[g]),
            .shutdown  (resp_shutdown[g])
        );
    end
endmodule

// File: tb/sexit_rdv_ctrl_tb.sv
module sexit_rdv_ctrl_tb_top;
    localparam int N = 4;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          sess_open, exit_req, init_virt;
    logic [N-1:0]  resp_active, resp_virt;
    logic [2*N-1:0] resp_prior;
    logic          exit_bcast, cont_msg, close_msg, sess_flag, all_acked;
    logic [N-1:0]  ack_vec;
    logic [3:0]    init_pin_mask;
    logic          init_shutdown, init_done;
    logic [N-1:0]  resp_ack, resp_halt, resp_wait_sipi, resp_bsp_clr, resp_resume, resp_shutdown;
    logic [4*N-1:0] resp_pin_mask;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;   // 50 MHz

    sexit_rdv_ctrl #(.N_RESP(N)) dut_i (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [N-1:0] f_sel(input logic [N-1:0] a, input logic [2*N-1:0] p,
                                           input logic [1:0] code);
        logic [N-1:0] r = '0;
        for (int i = 0; i < N; i++) r[i] = a[i] && (p[2*i +: 2] == code);
        return r;
    endfunction

    function automatic logic [4*N-1:0] f_mask(input logic [N-1:0] a);
        logic [4*N-1:0] r;
        for (int i = 0; i < N; i++) r[4*i +: 4] = a[i] ? 4'h0 : 4'hF;
        return r;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; sess_open = 0; exit_req = 0; init_virt = 0;
        resp_active = '0; resp_virt = '0; resp_prior = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic open_sess();
        sess_open = 1'b1;
        @(negedge clk);
        sess_open = 1'b0;
        chk("R2 flag", sess_flag, 1);
        chk("R2 init mask", init_pin_mask, 4'hF);
        chk("R2 resp mask", resp_pin_mask, {4*N{1'b1}});
    endtask

    // Full exit sequence with per-cycle expected values.
    task automatic run_exit(input logic [N-1:0] a, input logic [2*N-1:0] p);
        resp_active = a; resp_prior = p; resp_virt = '0; init_virt = 0;
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        chk("R3 bcast", exit_bcast, 1);
        @(negedge clk);
        chk("R3 bcast single", exit_bcast, 0);
        chk("R3 ack cleared", ack_vec, 0);
        chk("R4 ack pulse", resp_ack, a);
        resp_prior = ~p;   // R11: late change must not matter
        if (a != '0) begin
            @(negedge clk);
            chk("R4 ack vec", ack_vec, a);
            chk("R7 no early cont", cont_msg, 0);
        end
        @(negedge clk);
        chk("R7 cont", cont_msg, 1);
        chk("R7 close not yet", close_msg, 0);
        @(negedge clk);
        chk("R7 close", close_msg, 1);
        chk("R7 cont single", cont_msg, 0);
        chk("R9 resp mask", resp_pin_mask, f_mask(a));
        chk("R10 halt", resp_halt, f_sel(a, p, 2'b01));
        chk("R10 bsp clr", resp_bsp_clr, f_sel(a, p, 2'b10));
        chk("R10 wait sipi", resp_wait_sipi, f_sel(a, p, 2'b10));
        chk("R11 resume", resp_resume, f_sel(a, p, 2'b00) | f_sel(a, p, 2'b11));
        chk("R8 flag still set", sess_flag, 1);
        @(negedge clk);
        chk("R8 flag clear", sess_flag, 0);
        chk("R8 init mask", init_pin_mask, 0);
        chk("R8 init done", init_done, 1);
        chk("R7 close single", close_msg, 0);
        @(negedge clk);
        chk("R8 done single", init_done, 0);
    endtask

    initial begin
        void'($urandom(11));
        do_reset();
        // R1 reset state
        chk("R1 flag", sess_flag, 0);
        chk("R1 masks", {init_pin_mask, resp_pin_mask}, 0);
        chk("R1 ack vec", ack_vec, 0);
        chk("R1 msgs", {exit_bcast, cont_msg, close_msg}, 0);
        // R2 exit ignored without session
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        chk("R2 no bcast", exit_bcast, 0);
        @(negedge clk);
        chk("R2 no bcast later", {exit_bcast, resp_ack}, 0);

        // Directed corners
        open_sess(); run_exit(4'b0000, 8'h00);
        open_sess(); run_exit(4'b1111, 8'h55);
        open_sess(); run_exit(4'b1111, 8'hAA);
        open_sess(); run_exit(4'b0101, 8'hE4);
        open_sess(); run_exit(4'b1000, 8'h1B);

        // Random rounds
        for (int k = 0; k < 24; k++) begin
            open_sess();
            run_exit(N'($urandom()), 8'($urandom()));
        end

        // R5 responder in virtualization operation
        open_sess();
        resp_active = 4'b1011; resp_virt = 4'b0010; resp_prior = '0;
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        @(negedge clk);
        chk("R5 shutdown", resp_shutdown, 4'b0010);
        chk("R5 ack others", resp_ack, 4'b1001);
        for (int j = 0; j < 6; j++) begin
            @(negedge clk);
            chk("R5 no cont", cont_msg, 0);
        end
        chk("R5 shutdown held", resp_shutdown, 4'b0010);
        chk("R5 ack vec", ack_vec, 4'b1001);

        // R6 initiator in virtualization operation
        do_reset();
        open_sess();
        resp_active = 4'b0001; init_virt = 1'b1;
        exit_req = 1'b1;
        @(negedge clk);
        exit_req = 1'b0;
        @(negedge clk);
        chk("R6 init shutdown", init_shutdown, 1);
        for (int j = 0; j < 5; j++) begin
            @(negedge clk);
            chk("R6 no cont", cont_msg, 0);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule